// File: doc/BRIEF.md
# Mask-decoded slave register bank

This block sits behind a simple bus slave and maps a window of the bus address space onto two register arrays. A bus address belongs to the block when the address ANDed with a fixed mask equals a fixed match value; the bits left free by the mask form an offset, and the low bits of that offset select a register. Writes land in an internal bank of write registers, while reads are served from an array of read registers that the surrounding logic supplies. Several slaves can share one bus by giving each a mask/value pair that claims its own window.

The read path is purely combinational, from address to hit flag to read data, so the bus can sample read data in the same cycle as the address. The write path is registered once before the bank, which keeps the decode off the register update path. Every completed write raises a one-cycle event bit for the register it changed. In a 32-bit build a narrow access touches only the low 16 bits.

Top module: `mask_slave_regbank`

## Requirements
- R1: `bus_hit_o` is 1 in the same cycle exactly when `(bus_addr_i & ADDR_MASK) == ADDR_VALUE`. With the default mask 0xE000 and value 0xA000, addresses 0xA000 to 0xBFFF hit.
- R2: The register index is taken from the offset `bus_addr_i & ~ADDR_MASK`. A write register exists only when the offset is below 2^WR_IDX_W. A read register exists only when the offset is below 2^RD_IDX_W.
- R3: A write (`bus_wr_i`=1 at a rising edge, with a hit and an existing index) is captured at that edge. The selected write register shows the new data after the next rising edge.
- R4: When `bus_wide_i`=1, an access covers the full register. In the 32-bit build, `bus_wide_i`=0 writes only bits [15:0] and leaves bits [31:16] unchanged. A read with `bus_wide_i`=0 returns bits [31:16] as zero. In the 16-bit build, `bus_wide_i` has no effect.
- R5: Each write raises exactly one bit of `wr_event_o`, the bit of the written register, for exactly one cycle. The bit rises in the same cycle the new value appears.
- R6: `bus_rdata_o` is combinational. It equals read register k whenever `bus_rd_i`=1, the address hits and the offset k exists. Otherwise it is zero.
- R7: A write whose address misses the window changes no register and raises no event bit.
- R8: A write that hits but whose offset has no write register changes no register and raises no event bit.
- R9: While `rst_ni` is 0, all write registers and all event bits are zero.
- R10: The flattened vectors are row-major. Register k occupies bits [k*DW +: DW] of `wr_regs_o` and `rd_regs_i`, and event bit k belongs to write register k. DW is 32 when WIDE_MODE=1 and 16 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | ADDR_W | Bus address |
| bus_wide_i | input | 1 | Access width: 1 full register, 0 low 16 bits |
| bus_wdata_i | input | DW | Write data |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_rdata_o | output | DW | Combinational read data, zero when not selected |
| bus_hit_o | output | 1 | Address lies in this slave's window |
| wr_regs_o | output | 2^WR_IDX_W*DW | Flattened write registers |
| wr_event_o | output | 2^WR_IDX_W | Per-register one-cycle write event |
| rd_regs_i | input | 2^RD_IDX_W*DW | Flattened read registers |

## Verification
The assertions run on every cycle. They check the window match of the hit flag and that a miss always yields zero read data. They also check that at most one event bit is set, that every event traces back to a hit write two edges earlier, and that the write bank never changes in a cycle without an event. Only the bench scenarios can show the values themselves. These are the merge of narrow writes into the upper half, the choice of register from the masked offset, the silent drop of writes to missing indices, and the row-major placement in both flattened vectors.

// File: rtl/mask_regbank_pkg.sv
package mask_regbank_pkg;
  localparam int unsigned NARROW_W = 16;
  localparam int unsigned WIDE_W   = 32;

  typedef enum logic {
    ACC_NARROW = 1'b0,
    ACC_WIDE   = 1'b1
  } acc_mode_e;
endpackage

// File: rtl/regbank_addr_dec.sv
module regbank_addr_dec #(
  parameter int unsigned ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] ADDR_MASK  = 16'hE000,
  parameter logic [ADDR_W-1:0] ADDR_VALUE = 16'hA000,
  parameter int unsigned WR_IDX_W   = 3,
  parameter int unsigned RD_IDX_W   = 2
) (
  input  logic [ADDR_W-1:0]   addr_i,
  output logic                hit_o,
  output logic [WR_IDX_W-1:0] wr_idx_o,
  output logic                wr_idx_ok_o,
  output logic [RD_IDX_W-1:0] rd_idx_o,
  output logic                rd_idx_ok_o
);
  logic [ADDR_W-1:0] offset;

  always_comb begin
    hit_o       = (addr_i & ADDR_MASK) == ADDR_VALUE;
    offset      = addr_i & ~ADDR_MASK;
    wr_idx_o    = offset[WR_IDX_W-1:0];
    rd_idx_o    = offset[RD_IDX_W-1:0];
    // index exists only if no offset bit above it is set
    wr_idx_ok_o = (offset >> WR_IDX_W) == '0;
    rd_idx_ok_o = (offset >> RD_IDX_W) == '0;
  end
endmodule

// File: rtl/regbank_wr_bank.sv
module regbank_wr_bank
  import mask_regbank_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned IDX_W = 3,
  localparam int unsigned NREG = 1 << IDX_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [DW-1:0]      wdata_i,
  input  acc_mode_e          mode_i,
  output logic [NREG*DW-1:0] regs_o,
  output logic [NREG-1:0]    event_o
);
  logic             en_q;
  logic [IDX_W-1:0] idx_q;
  logic [DW-1:0]    data_q;
  acc_mode_e        mode_q;

  // one-cycle latch on the write path, decode stays off the bank update
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      idx_q  <= '0;
      data_q <= '0;
      mode_q <= ACC_WIDE;
    end else begin
      en_q   <= wr_en_i;
      idx_q  <= idx_i;
      data_q <= wdata_i;
      mode_q <= mode_i;
    end
  end

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    logic [DW-1:0] cur;
    logic [DW-1:0] nxt;
    logic          sel;

    assign cur = regs_o[k*DW +: DW];
    assign sel = en_q && (idx_q == IDX_W'(k));

    if (DW > NARROW_W) begin : g_merge
      assign nxt = (mode_q == ACC_NARROW) ? {cur[DW-1:NARROW_W], data_q[NARROW_W-1:0]}
                                          : data_q;
    end else begin : g_full
      assign nxt = data_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_o[k*DW +: DW] <= '0;
        event_o[k]         <= 1'b0;
      end else begin
        event_o[k] <= sel;
        if (sel) regs_o[k*DW +: DW] <= nxt;
      end
    end
  end
endmodule

// File: rtl/regbank_rd_mux.sv
module regbank_rd_mux
  import mask_regbank_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned IDX_W = 2,
  localparam int unsigned NREG = 1 << IDX_W
) (
  input  logic [NREG*DW-1:0] regs_i,
  input  logic               sel_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  acc_mode_e          mode_i,
  output logic [DW-1:0]      rdata_o
);
  logic [DW-1:0] word;

  assign word = regs_i[idx_i*DW +: DW];

  if (DW > NARROW_W) begin : g_narrow
    always_comb begin
      rdata_o = '0;
      if (sel_i) begin
        rdata_o = word;
        if (mode_i == ACC_NARROW) rdata_o[DW-1:NARROW_W] = '0;
      end
    end
  end else begin : g_plain
    logic unused_mode;
    assign unused_mode = mode_i;
    assign rdata_o     = sel_i ? word : '0;
  end
endmodule

// File: rtl/mask_slave_regbank.sv
module mask_slave_regbank
  import mask_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] ADDR_MASK  = 16'hE000,
  parameter logic [ADDR_W-1:0] ADDR_VALUE = 16'hA000,
  parameter bit          WIDE_MODE  = 1'b1,
  parameter int unsigned WR_IDX_W   = 3,
  parameter int unsigned RD_IDX_W   = 2,
  localparam int unsigned DW      = WIDE_MODE ? WIDE_W : NARROW_W,
  localparam int unsigned N_WR    = 1 << WR_IDX_W,
  localparam int unsigned N_RD    = 1 << RD_IDX_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic               bus_wide_i,
  input  logic [DW-1:0]      bus_wdata_i,
  input  logic               bus_wr_i,
  input  logic               bus_rd_i,
  output logic [DW-1:0]      bus_rdata_o,
  output logic               bus_hit_o,
  output logic [N_WR*DW-1:0] wr_regs_o,
  output logic [N_WR-1:0]    wr_event_o,
  input  logic [N_RD*DW-1:0] rd_regs_i
);
  logic [WR_IDX_W-1:0] wr_idx;
  logic [RD_IDX_W-1:0] rd_idx;
  logic                wr_ok, rd_ok;
  acc_mode_e           mode;

  assign mode = bus_wide_i ? ACC_WIDE : ACC_NARROW;

  regbank_addr_dec #(
    .ADDR_W(ADDR_W), .ADDR_MASK(ADDR_MASK), .ADDR_VALUE(ADDR_VALUE),
    .WR_IDX_W(WR_IDX_W), .RD_IDX_W(RD_IDX_W)
  ) dec_i (
    .addr_i(bus_addr_i), .hit_o(bus_hit_o),
    .wr_idx_o(wr_idx), .wr_idx_ok_o(wr_ok),
    .rd_idx_o(rd_idx), .rd_idx_ok_o(rd_ok)
  );

  regbank_wr_bank #(.DW(DW), .IDX_W(WR_IDX_W)) wr_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(bus_wr_i && bus_hit_o && wr_ok),
    .idx_i(wr_idx), .wdata_i(bus_wdata_i), .mode_i(mode),
    .regs_o(wr_regs_o), .event_o(wr_event_o)
  );

  regbank_rd_mux #(.DW(DW), .IDX_W(RD_IDX_W)) rd_i (
    .regs_i(rd_regs_i), .sel_i(bus_rd_i && bus_hit_o && rd_ok),
    .idx_i(rd_idx), .mode_i(mode), .rdata_o(bus_rdata_o)
  );
endmodule

// File: rtl/mask_slave_regbank_chk.sv
module mask_slave_regbank_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] ADDR_MASK  = 16'hE000,
  parameter logic [ADDR_W-1:0] ADDR_VALUE = 16'hA000,
  parameter int unsigned DW   = 32,
  parameter int unsigned N_WR = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [ADDR_W-1:0]  bus_addr_i,
  input logic               bus_wr_i,
  input logic               bus_hit_o,
  input logic [DW-1:0]      bus_rdata_o,
  input logic [N_WR*DW-1:0] wr_regs_o,
  input logic [N_WR-1:0]    wr_event_o
);
  a_r1_hit_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_hit_o == ((bus_addr_i & ADDR_MASK) == ADDR_VALUE));

  a_r6_miss_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_hit_o |-> bus_rdata_o == '0);

  a_r5_event_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_event_o));

  a_r7_event_from_hit_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_event_o != '0) |-> $past(bus_wr_i && bus_hit_o, 2));

  a_r3_bank_quiet_without_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_event_o == '0) |-> $stable(wr_regs_o));
endmodule

bind mask_slave_regbank mask_slave_regbank_chk #(
  .ADDR_W(ADDR_W), .ADDR_MASK(ADDR_MASK), .ADDR_VALUE(ADDR_VALUE),
  .DW(DW), .N_WR(N_WR)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_addr_i(bus_addr_i),
  .bus_wr_i(bus_wr_i), .bus_hit_o(bus_hit_o), .bus_rdata_o(bus_rdata_o),
  .wr_regs_o(wr_regs_o), .wr_event_o(wr_event_o)
);

// File: tb/mask_slave_regbank_tb_top.sv
`timescale 1ns/1ps
module mask_slave_regbank_tb_top;
  localparam int unsigned AW = 16;
  localparam logic [AW-1:0] MASK = 16'hE000;
  localparam logic [AW-1:0] VAL  = 16'hA000;
  localparam int unsigned DW = 32;
  localparam int unsigned NW = 8;
  localparam int unsigned NR = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic wide = 1'b1, wr = 1'b0, rd = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic hit;
  logic [NW*DW-1:0] wregs;
  logic [NW-1:0] wev;
  logic [NR*DW-1:0] rregs;

  logic [DW-1:0] exp_w [NW];
  logic [DW-1:0] rd_model [NR];

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mask_slave_regbank dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wide_i(wide),
    .bus_wdata_i(wdata), .bus_wr_i(wr), .bus_rd_i(rd), .bus_rdata_o(rdata),
    .bus_hit_o(hit), .wr_regs_o(wregs), .wr_event_o(wev), .rd_regs_i(rregs)
  );

  always_comb for (int k = 0; k < NR; k++) rregs[k*DW +: DW] = rd_model[k];

  function automatic bit f_hit(logic [AW-1:0] a);
    return (a & MASK) == VAL;
  endfunction
  function automatic logic [AW-1:0] f_off(logic [AW-1:0] a);
    return a & ~MASK;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_bank(string req);
    for (int k = 0; k < NW; k++) chk(req, 64'(wregs[k*DW +: DW]), 64'(exp_w[k]));
  endtask

  // drive one write, then check event/bank in update cycle and pulse end after
  task automatic do_write(logic [AW-1:0] a, logic [DW-1:0] d, logic w, string req);
    logic [AW-1:0] off;
    logic [NW-1:0] ev_exp;
    off = f_off(a);
    ev_exp = '0;
    @(negedge clk);
    addr = a; wdata = d; wide = w; wr = 1'b1;
    #1 chk("R1", 64'(hit), 64'(f_hit(a)));
    @(negedge clk);
    wr = 1'b0;
    if (f_hit(a) && off < NW) begin
      ev_exp[off] = 1'b1;
      exp_w[off] = w ? d : {exp_w[off][DW-1:16], d[15:0]};
    end
    @(negedge clk);
    chk({req, " event"}, 64'(wev), 64'(ev_exp));
    chk_bank(req);
    @(negedge clk);
    chk("R5 pulse end", 64'(wev), 64'h0);
  endtask

  task automatic do_read(logic [AW-1:0] a, logic w, logic r, string req);
    logic [AW-1:0] off;
    logic [DW-1:0] e;
    off = f_off(a);
    @(negedge clk);
    addr = a; wide = w; rd = r;
    #1;
    e = '0;
    if (r && f_hit(a) && off < NR) begin
      e = rd_model[off];
      if (!w) e[DW-1:16] = '0;
    end
    chk(req, 64'(rdata), 64'(e));
    chk("R1", 64'(hit), 64'(f_hit(a)));
    rd = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < NW; k++) exp_w[k] = '0;
    for (int k = 0; k < NR; k++) rd_model[k] = $urandom();
    repeat (3) @(negedge clk);
    chk_bank("R9 reset regs");
    chk("R9 reset events", 64'(wev), 64'h0);
    rst_n = 1'b1;

    // R1 window boundaries
    do_read(16'h9FFF, 1'b1, 1'b1, "R1 below window");
    do_read(16'hA000, 1'b1, 1'b1, "R6 first read reg");
    do_read(16'hC000, 1'b1, 1'b1, "R1 above window");

    // R3/R10 full writes land at row-major slot
    do_write(16'hA000, 32'h1111_2222, 1'b1, "R3 reg0");
    do_write(16'hA007, 32'hDEAD_BEEF, 1'b1, "R10 last reg");
    // R4 narrow write keeps upper half
    do_write(16'hA007, 32'h0000_5A5A, 1'b0, "R4 narrow write");
    chk("R4 upper kept", 64'(wregs[7*DW+16 +: 16]), 64'hDEAD);
    // R7 out-of-window write ignored
    do_write(16'h2003, 32'hFFFF_FFFF, 1'b1, "R7 miss write");
    // R8 hit but no register at offset 8
    do_write(16'hA008, 32'hFFFF_FFFF, 1'b1, "R8 missing index");
    do_write(16'hBFFF, 32'hFFFF_FFFF, 1'b1, "R8 top of window");
    // R6/R4 reads
    do_read(16'hA003, 1'b1, 1'b1, "R6 read reg3");
    do_read(16'hA002, 1'b0, 1'b1, "R4 narrow read");
    do_read(16'hA002, 1'b1, 1'b0, "R6 no strobe");
    do_read(16'hA004, 1'b1, 1'b1, "R2 read offset beyond");

    // random mix
    for (int i = 0; i < 200; i++) begin
      logic [AW-1:0] a;
      int sel;
      sel = $urandom_range(0, 3);
      if (sel == 0)      a = VAL | AW'($urandom_range(0, 11));
      else if (sel == 1) a = VAL | AW'($urandom_range(0, 15));
      else if (sel == 2) a = AW'($urandom());
      else               a = VAL | AW'($urandom_range(0, 3));
      if ($urandom_range(0, 1) == 1)
        do_write(a, $urandom(), 1'($urandom_range(0, 1)), "R2 random write");
      else begin
        if ($urandom_range(0, 7) == 0) rd_model[$urandom_range(0, NR-1)] = $urandom();
        do_read(a, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) != 0), "R6 random read");
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule